// File: doc/BRIEF.md
# Daisy-Chain Message Bus Head Controller

This block sits at the head of a ring of 16-bit register nodes. Its transmit word stream feeds the first node, and the last node's output comes back to its receive port. Every message opens with a zero word and then the sync word 0xEB90. A command word and a start address follow, and then a payload. Each node forwards every word with a one-cycle delay. A node acts only on payload slots whose address falls inside its own range. Read data therefore comes back in the returning stream, not through a read multiplexer.

Right after reset the controller sends a single auto-define message. The nodes use it to claim their address ranges, and the controller keeps the total address space that comes back. It then serves one host request at a time. A host request carries a direction, a start address and a length. For a write, the controller pulls the write data over a valid/ready stream. It frames the request, sends it, and finds the returning copy by the same zero-then-sync pattern. For a read, it strobes each returned payload word to the host. Between messages it sends only zero words.

The host request port is valid/ready: a request is taken on a cycle where both `req_valid` and `req_ready` are high. `req_ready` is high only when no message is outstanding. The write-data stream is valid/ready as well. The controller raises `wdata_ready` in each write payload cycle. The ring cannot stall, so the host must keep `wdata_valid` high for all of these cycles. The read-data output has no ready: the ring delivers one word per cycle and the host must take every `rdata_valid` word.

Top module: `chain_head_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `ring_tx` is 0x0000, and both `req_ready` and `map_valid` are low.
- R2: The first message after reset is the four words 0x0000, 0xEB90, 0xFE00, 0x0000, in that order. Nothing follows them as payload.
- R3: The word that comes back in the address slot of the auto-define message is held on `map_end`, and `map_valid` then rises and stays high. `req_ready` is never high before `map_valid`.
- R4: A read of length L at address A sends 0x0000, 0xEB90, a command word, A, and then L zero words. In the command word, bits 15:10 are zero, bit 9 is 0 and bits 8:0 hold L.
- R5: A write of length L at address A sends 0x0000, 0xEB90, a command word, A, and then L payload words. In the command word, bit 9 is 1, bits 8:0 hold L and all other bits are zero. The payload words are the host's write words in the order they were accepted.
- R6: For a read, the controller strobes `rdata_valid` once for each of the L returned payload words, in ring order. `rd_done` is high in the same cycle as the last of these words.
- R7: A request with a length of 0, or a length above 511, raises `req_err` in the cycle after it is accepted. No message is sent for it, and `req_ready` stays high.
- R8: `req_ready` is low from the cycle after a request is accepted until the returning message has fully passed the receive port. It is low in every cycle in which `rdata_valid` is high.
- R9: When no message is being sent, `ring_tx` carries 0x0000.
- R10: If `wdata_valid` is low in a write payload cycle, that slot carries 0x0000 and `req_err` pulses in the next cycle. Later slots take the host's words in order, starting with the word that was not taken.
- R11: A length of exactly 511 is accepted and carried out in full, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Start word address |
| req_len | input | LEN_W+1 | Word count; the extra bit lets out-of-range lengths reach the check |
| req_err | output | 1 | One-cycle pulse: request rejected, or a write word missing |
| wdata_valid | input | 1 | Write word valid |
| wdata_ready | output | 1 | Write payload slot open this cycle |
| wdata | input | 16 | Write word |
| rdata_valid | output | 1 | Returned read word strobe |
| rdata | output | 16 | Returned read word |
| rd_done | output | 1 | Pulse with the final read word |
| map_valid | output | 1 | Auto-define result captured |
| map_end | output | 16 | End address of the last node + 1 |
| ring_tx | output | 16 | Word stream to the first node |
| ring_rx | input | 16 | Word stream from the last node |

## Verification
The bench builds the controller with its default LEN_W of 9. With that value the 511-word limit and the 512 rejection are both exercised, not only scaled-down versions of them. The bench models the ring as a three-cycle delay line in front of a 64-word memory. The 64-word memory is small enough that the bench can compute every expected word for every address and length in a sweep over lengths 1 to 8 at several start addresses, including addresses that wrap. The same memory also gives a full 511-word transfer that overwrites itself many times, with a result the bench can still compute by arithmetic.

// File: rtl/chain_head_pkg.sv
package chain_head_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] NULL_WORD   = 16'h0000;
  localparam logic [WORD_W-1:0] SYNC_WORD   = 16'hEB90;
  localparam logic [WORD_W-1:0] AUTODEF_CMD = 16'hFE00;

  typedef enum logic [1:0] {
    MK_AUTO  = 2'd0,
    MK_READ  = 2'd1,
    MK_WRITE = 2'd2
  } msg_kind_e;
endpackage

// File: rtl/chain_req_gate.sv
module chain_req_gate
  import chain_head_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_addr,
  input  logic [LEN_W:0]    req_len,
  output logic              req_ready,
  output logic              rej_err,
  output logic              go,
  output logic              go_write,
  output logic [WORD_W-1:0] go_addr,
  output logic [LEN_W-1:0]  go_len
);
  logic accept;
  logic len_ok;

  assign req_ready = idle;
  assign accept    = req_valid && req_ready;
  // a legal length is non-zero and fits in LEN_W bits
  assign len_ok    = (req_len != '0) && !req_len[LEN_W];
  assign go        = accept && len_ok;
  assign go_write  = req_write;
  assign go_addr   = req_addr;
  assign go_len    = req_len[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) rej_err <= 1'b0;
    else        rej_err <= accept && !len_ok;
  end
endmodule

// File: rtl/chain_tx_framer.sv
module chain_tx_framer
  import chain_head_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_write,
  input  logic [WORD_W-1:0] go_addr,
  input  logic [LEN_W-1:0]  go_len,
  input  logic              rx_done,
  input  logic              wdata_valid,
  input  logic [WORD_W-1:0] wdata,
  output logic              wdata_ready,
  output logic [WORD_W-1:0] ring_tx,
  output logic              idle,
  output logic              gap_err,
  output logic              arm,
  output msg_kind_e         arm_kind,
  output logic [LEN_W-1:0]  arm_len
);
  localparam int PAD_W = WORD_W - LEN_W - 1;

  typedef enum logic [2:0] {
    F_BOOT, F_IDLE, F_NULL, F_SYNC, F_CMD, F_ADDR, F_PAY, F_WAIT
  } fr_state_e;

  fr_state_e         st;
  msg_kind_e         kind;
  logic [WORD_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] cmd_word;
  logic              pay_wr;

  assign cmd_word    = (kind == MK_AUTO) ? AUTODEF_CMD
                     : {{PAD_W{1'b0}}, (kind == MK_WRITE), len_q};
  assign pay_wr      = (st == F_PAY) && (kind == MK_WRITE);
  assign wdata_ready = pay_wr;
  assign idle        = (st == F_IDLE);
  assign ring_tx     = tx_q;
  assign arm         = (st == F_NULL);
  assign arm_kind    = kind;
  assign arm_len     = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= F_BOOT;
      kind    <= MK_AUTO;
      addr_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      tx_q    <= NULL_WORD;
      gap_err <= 1'b0;
    end else begin
      gap_err <= pay_wr && !wdata_valid;
      unique case (st)
        F_BOOT: begin
          kind   <= MK_AUTO;
          addr_q <= '0;
          len_q  <= '0;
          tx_q   <= NULL_WORD;
          st     <= F_NULL;
        end
        F_IDLE: begin
          tx_q <= NULL_WORD;
          if (go) begin
            kind   <= go_write ? MK_WRITE : MK_READ;
            addr_q <= go_addr;
            len_q  <= go_len;
            st     <= F_NULL;
          end
        end
        F_NULL: begin
          tx_q <= NULL_WORD;
          st   <= F_SYNC;
        end
        F_SYNC: begin
          tx_q <= SYNC_WORD;
          st   <= F_CMD;
        end
        F_CMD: begin
          tx_q <= cmd_word;
          st   <= F_ADDR;
        end
        F_ADDR: begin
          tx_q  <= addr_q;
          cnt_q <= len_q;
          st    <= (kind == MK_AUTO) ? F_WAIT : F_PAY;
        end
        F_PAY: begin
          tx_q  <= (pay_wr && wdata_valid) ? wdata : NULL_WORD;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == LEN_W'(1)) st <= F_WAIT;
        end
        F_WAIT: begin
          tx_q <= NULL_WORD;
          if (rx_done) st <= F_IDLE;
        end
        default: st <= F_BOOT;
      endcase
    end
  end
endmodule

// File: rtl/chain_rx_parser.sv
module chain_rx_parser
  import chain_head_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ring_rx,
  input  logic              arm,
  input  msg_kind_e         arm_kind,
  input  logic [LEN_W-1:0]  arm_len,
  output logic              rx_done,
  output logic              rdata_valid,
  output logic [WORD_W-1:0] rdata,
  output logic              rd_done,
  output logic              map_valid,
  output logic [WORD_W-1:0] map_end
);
  typedef enum logic [1:0] {P_HUNT, P_CMD, P_ADDR, P_PAY} px_state_e;

  px_state_e         st;
  logic [WORD_W-1:0] rx_q;
  logic [WORD_W-1:0] prv_q;
  logic              armed;
  msg_kind_e         kind;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              hdr_seen;

  assign hdr_seen = armed && (prv_q == NULL_WORD) && (rx_q == SYNC_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= P_HUNT;
      rx_q        <= NULL_WORD;
      prv_q       <= NULL_WORD;
      armed       <= 1'b0;
      kind        <= MK_AUTO;
      len_q       <= '0;
      cnt_q       <= '0;
      rx_done     <= 1'b0;
      rdata_valid <= 1'b0;
      rdata       <= '0;
      rd_done     <= 1'b0;
      map_valid   <= 1'b0;
      map_end     <= '0;
    end else begin
      rx_q        <= ring_rx;
      prv_q       <= rx_q;
      rx_done     <= 1'b0;
      rdata_valid <= 1'b0;
      rd_done     <= 1'b0;
      unique case (st)
        P_HUNT: if (hdr_seen) st <= P_CMD;
        P_CMD:  st <= P_ADDR;
        P_ADDR: begin
          if (kind == MK_AUTO) begin
            map_end   <= rx_q;
            map_valid <= 1'b1;
            rx_done   <= 1'b1;
            armed     <= 1'b0;
            st        <= P_HUNT;
          end else begin
            cnt_q <= len_q;
            st    <= P_PAY;
          end
        end
        P_PAY: begin
          if (kind == MK_READ) begin
            rdata_valid <= 1'b1;
            rdata       <= rx_q;
          end
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == LEN_W'(1)) begin
            rx_done <= 1'b1;
            rd_done <= (kind == MK_READ);
            armed   <= 1'b0;
            st      <= P_HUNT;
          end
        end
        default: st <= P_HUNT;
      endcase
      if (arm) begin
        armed <= 1'b1;
        kind  <= arm_kind;
        len_q <= arm_len;
      end
    end
  end
endmodule

// File: rtl/chain_head_ctrl.sv
module chain_head_ctrl
  import chain_head_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [15:0]       req_addr,
  input  logic [LEN_W:0]    req_len,
  output logic              req_err,
  input  logic              wdata_valid,
  output logic              wdata_ready,
  input  logic [15:0]       wdata,
  output logic              rdata_valid,
  output logic [15:0]       rdata,
  output logic              rd_done,
  output logic              map_valid,
  output logic [15:0]       map_end,
  output logic [15:0]       ring_tx,
  input  logic [15:0]       ring_rx
);
  logic              idle;
  logic              rej_err;
  logic              gap_err;
  logic              go;
  logic              go_write;
  logic [WORD_W-1:0] go_addr;
  logic [LEN_W-1:0]  go_len;
  logic              rx_done;
  logic              arm;
  msg_kind_e         arm_kind;
  logic [LEN_W-1:0]  arm_len;

  assign req_err = rej_err || gap_err;

  chain_req_gate #(.LEN_W(LEN_W)) gate_i (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_ready(req_ready), .rej_err(rej_err),
    .go(go), .go_write(go_write), .go_addr(go_addr), .go_len(go_len)
  );

  chain_tx_framer #(.LEN_W(LEN_W)) framer_i (
    .clk(clk), .rst_n(rst_n), .go(go), .go_write(go_write),
    .go_addr(go_addr), .go_len(go_len), .rx_done(rx_done),
    .wdata_valid(wdata_valid), .wdata(wdata), .wdata_ready(wdata_ready),
    .ring_tx(ring_tx), .idle(idle), .gap_err(gap_err),
    .arm(arm), .arm_kind(arm_kind), .arm_len(arm_len)
  );

  chain_rx_parser #(.LEN_W(LEN_W)) parser_i (
    .clk(clk), .rst_n(rst_n), .ring_rx(ring_rx), .arm(arm),
    .arm_kind(arm_kind), .arm_len(arm_len), .rx_done(rx_done),
    .rdata_valid(rdata_valid), .rdata(rdata), .rd_done(rd_done),
    .map_valid(map_valid), .map_end(map_end)
  );
endmodule

// File: rtl/chain_head_chk.sv
module chain_head_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_err,
  input logic        wdata_valid,
  input logic        wdata_ready,
  input logic        rdata_valid,
  input logic        rd_done,
  input logic        map_valid,
  input logic [15:0] map_end,
  input logic [15:0] ring_tx
);
  // R8
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> !req_ready);

  // R6
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rdata_valid);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> ($past(req_valid && req_ready) || $past(wdata_ready && !wdata_valid)));

  // R3
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |=> (map_valid && $stable(map_end)));

  // R3
  ready_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> map_valid);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(req_ready)) |-> (ring_tx == 16'h0000));
endmodule

bind chain_head_ctrl chain_head_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_err(req_err), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
  .rdata_valid(rdata_valid), .rd_done(rd_done), .map_valid(map_valid),
  .map_end(map_end), .ring_tx(ring_tx)
);

// File: tb/chain_head_ctrl_tb_top.sv
module chain_head_ctrl_tb_top;
  localparam int LEN_W = 9;
  localparam int DLY   = 3;
  localparam int MW    = 64;
  localparam logic [15:0] SPACE = 16'h0060;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [LEN_W:0] req_len = '0;
  logic        req_err;
  logic        wdata_valid = 1'b0;
  logic        wdata_ready;
  logic [15:0] wdata = '0;
  logic        rdata_valid;
  logic [15:0] rdata;
  logic        rd_done;
  logic        map_valid;
  logic [15:0] map_end;
  logic [15:0] ring_tx;
  logic [15:0] ring_rx;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  chain_head_ctrl #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_err(req_err), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
    .wdata(wdata), .rdata_valid(rdata_valid), .rdata(rdata), .rd_done(rd_done),
    .map_valid(map_valid), .map_end(map_end), .ring_tx(ring_tx), .ring_rx(ring_rx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ring model: delay line in front of a word memory
  logic [15:0] dl [DLY];
  logic [15:0] mem [MW];
  logic [15:0] pay_log [512];
  assign ring_rx = dl[DLY-1];
  int mst = 0, m_k = 0, m_len = 0, msg_cnt = 0, idle_bad = 0, err_cnt = 0;
  logic [15:0] m_prev = '0, m_cmd = '0, m_addr = '0;
  bit ready_before_map = 0;

  initial begin
    for (int i = 0; i < DLY; i++) dl[i] = '0;
    for (int i = 0; i < MW; i++) mem[i] = '0;
  end

  always @(negedge clk) begin
    logic [15:0] w, o;
    w = ring_tx;
    o = w;
    if (req_err) err_cnt++;
    if (rst_n && req_ready && !map_valid) ready_before_map = 1;
    case (mst)
      0: if (m_prev == 16'h0000 && w == 16'hEB90) mst = 1;
         else if (w != 16'h0000) idle_bad++;
      1: begin m_cmd = w; m_len = int'(w[8:0]); mst = 2; end
      2: begin
        m_addr = w;
        m_k = 0;
        if (m_cmd == 16'hFE00) begin o = w + SPACE; mst = 0; msg_cnt++; end
        else if (m_len == 0) begin mst = 0; msg_cnt++; end
        else mst = 3;
      end
      default: begin
        pay_log[m_k] = w;
        if (m_cmd[9]) mem[(int'(m_addr) + m_k) % MW] = w;
        else o = mem[(int'(m_addr) + m_k) % MW];
        m_k++;
        if (m_k == m_len) begin mst = 0; msg_cnt++; end
      end
    endcase
    m_prev = w;
    for (int i = DLY-1; i > 0; i--) dl[i] = dl[i-1];
    dl[0] = o;
  end

  // write data source
  logic [15:0] wsrc [512];
  int  widx = 0, gap_idx = -1;
  bit  wr_active = 0, gap_done = 0, wfire = 0;

  always @(negedge clk) begin
    if (wfire) widx++;
    if (wr_active && widx == gap_idx && !gap_done) begin
      wdata_valid = 1'b0;
      gap_done = 1;
    end else begin
      wdata_valid = wr_active;
      wdata = wsrc[widx % 512];
    end
    wfire = wdata_ready && wdata_valid;
  end

  logic [15:0] exp_mem [MW];
  initial for (int i = 0; i < MW; i++) exp_mem[i] = '0;

  function automatic logic [15:0] wval(input int a, input int k, input int n);
    return 16'((a * 7 + k * 13 + n * 31 + 16'h1234) ^ (k << 8));
  endfunction

  task automatic issue(input bit wr, input int a, input int n);
    int t = 0;
    @(negedge clk);
    while (!req_ready && t < 5000) begin @(negedge clk); t++; end
    req_valid = 1'b1; req_write = wr; req_addr = 16'(a); req_len = (LEN_W+1)'(n);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int prev_msgs);
    int t = 0;
    while ((msg_cnt == prev_msgs || !req_ready) && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic run_write(input int a, input int n, input int gap);
    int m0, e0;
    logic [15:0] ev;
    for (int k = 0; k < n; k++) wsrc[k] = wval(a, k, n);
    widx = 0; gap_idx = gap; gap_done = 0; wr_active = 1;
    m0 = msg_cnt; e0 = err_cnt;
    issue(1'b1, a, n);
    // R8: busy right after acceptance
    chk(!req_ready, "R8 ready low after write accept", req_ready, 0);
    wait_done(m0);
    wr_active = 0;
    // R5: command word and address
    chk(m_cmd == (16'h0200 | 16'(n)), "R5 write command word", m_cmd, 16'h0200 | 16'(n));
    chk(m_addr == 16'(a), "R5 write address", m_addr, a);
    begin
      bit ok = 1;
      int bad_k = -1;
      for (int k = 0; k < n; k++) begin
        if (gap >= 0 && k == gap) ev = 16'h0000;
        else if (gap >= 0 && k > gap) ev = wsrc[k-1];
        else ev = wsrc[k];
        exp_mem[(a + k) % MW] = ev;
        if (pay_log[k] != ev && ok) begin ok = 0; bad_k = k; end
      end
      if (gap >= 0)
        chk(ok, "R10 write payload with missing word", bad_k, -1);
      else
        chk(ok, "R5 write payload order", bad_k, -1);
    end
    if (gap >= 0) chk(err_cnt - e0 == 1, "R10 missing word error pulse", err_cnt - e0, 1);
    else          chk(err_cnt == e0, "R5 no error on full write", err_cnt - e0, 0);
  endtask

  task automatic run_read(input int a, input int n);
    int m0, got, t;
    bit ok, zero_ok, done_last, busy_ok;
    logic [15:0] rbuf [512];
    m0 = msg_cnt;
    issue(1'b0, a, n);
    chk(!req_ready, "R8 ready low after read accept", req_ready, 0);
    got = 0; t = 0; done_last = 0; busy_ok = 1;
    while (t < 5000) begin
      if (rdata_valid) begin
        if (req_ready) busy_ok = 0;
        if (got < 512) rbuf[got] = rdata;
        got++;
      end
      if (rd_done) begin done_last = rdata_valid; break; end
      @(negedge clk); t++;
    end
    chk(got == n, "R6 read word count", got, n);
    chk(done_last, "R6 done with last word", done_last, 1);
    chk(busy_ok, "R8 ready low while read data returns", busy_ok, 1);
    wait_done(m0);
    chk(m_cmd == 16'(n), "R4 read command word", m_cmd, n);
    chk(m_addr == 16'(a), "R4 read address", m_addr, a);
    ok = 1; zero_ok = 1;
    for (int k = 0; k < n && k < got; k++) begin
      if (rbuf[k] != exp_mem[(a + k) % MW]) ok = 0;
      if (pay_log[k] != 16'h0000) zero_ok = 0;
    end
    chk(zero_ok, "R4 read padding zeros", zero_ok, 1);
    if (n == 511) chk(ok, "R11 max length read data", ok, 1);
    else          chk(ok, "R6 read data matches", ok, 1);
  endtask

  task automatic run_reject(input int n);
    int m0, e0, i0;
    m0 = msg_cnt; e0 = err_cnt; i0 = idle_bad;
    issue(1'b0, 5, n);
    chk(req_err == 1'b1, "R7 reject error pulse", req_err, 1);
    chk(req_ready == 1'b1, "R7 ready stays high", req_ready, 1);
    repeat (10) @(negedge clk);
    chk(msg_cnt == m0 && idle_bad == i0, "R7 nothing sent on reject", msg_cnt - m0, 0);
  endtask

  initial begin
    int t;
    @(negedge clk);
    // R1
    chk(ring_tx == 16'h0000 && !req_ready && !map_valid, "R1 reset state",
        {ring_tx, 2'(req_ready), 2'(map_valid)}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ring_tx == 16'h0000 && !req_ready && !map_valid, "R1 first cycle after reset",
        {ring_tx, 2'(req_ready), 2'(map_valid)}, 0);
    t = 0;
    while (!map_valid && t < 1000) begin @(negedge clk); t++; end
    // R2
    chk(msg_cnt == 1 && m_cmd == 16'hFE00, "R2 auto-define command", m_cmd, 16'hFE00);
    chk(m_addr == 16'h0000, "R2 auto-define address word", m_addr, 0);
    // R3
    chk(map_end == SPACE, "R3 captured map end", map_end, SPACE);
    repeat (3) @(negedge clk);
    chk(req_ready && !ready_before_map, "R3 ready only after map", ready_before_map, 0);

    run_read(10, 4);
    for (int n = 1; n <= 8; n++) begin
      run_write(n * 3, n, -1);
      run_read(n * 3, n);
      run_write(60, n, -1);
      run_read(60, n);
    end
    run_write(20, 6, 2);
    run_read(20, 6);
    run_reject(0);
    run_reject(512);
    run_reject(1023);
    // R11
    run_write(3, 511, -1);
    run_read(3, 511);
    // R9
    chk(idle_bad == 0, "R9 zeros between messages", idle_bad, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule